// File: doc/BRIEF.md
# Master/slave SPI controller

This block is a four-wire, full-duplex SPI peripheral for a processor bus. Software sets it up through a control register and watches it through a status register. A single data register carries characters both ways: a read returns the receive holding buffer, and a write goes straight into the one shift register that both sends and receives. Receive is therefore double-buffered and transmit single-buffered. Characters are 8 or 16 bits wide, sent most significant bit first, in any of the four clock polarity/phase combinations.

As master, the block makes SCLK with a programmable divider and drives SCLK and MOSI. As slave, it brings the external SCLK and the active-low select into the system clock domain through synchronizer flip-flops, detects their edges there, and drives MISO only while it is selected. Three error conditions are flagged: a character that completes before the previous one was read, a data write during a transfer, and another device pulling select low while this unit is master. An interrupt line summarises the flags. Software can also poll them.

The register port has no handshake and applies no back-pressure. The data register takes a write only when no transfer is in progress. A write at any other time is dropped and recorded as a collision, so software must wait until the busy bit is clear before it writes.

Top module: `spi_ctl`

## Requirements
- R1: Register addresses are: 0 control, 1 status, 2 data. The control bits are: bit0 enable, bit1 master, bit2 clock polarity, bit3 clock phase, bit4 16-bit characters, bit5 interrupt enable, bits[15:8] divider N. After reset, control, status, irq and all output enables read 0.
- R2: When the unit is enabled, in master mode and idle, a data write starts a full-duplex transfer, MSB first, of 8 bits (bit4=0) or 16 bits (bit4=1). With MOSI looped back to MISO, the received character equals the written one.
- R3: SCLK rests at the polarity bit when idle and returns there after each transfer. With phase 0, the first bit is driven before the first SCLK edge and each bit is sampled on a leading edge. With phase 1, each bit is driven on a leading edge and sampled on a trailing edge.
- R4: In master mode each SCLK level lasts N+1 system clock cycles, which gives a bit rate of fclk/(2(N+1)), down to a fastest rate of fclk/2.
- R5: Each completed character is copied into the receive buffer, and a data read returns that buffer. In 8-bit mode, bits[15:8] of the read value are 0.
- R6: If a character completes while the receive buffer is still unread, status bit1 (overrun) sets and the buffer keeps its earlier contents.
- R7: A data write while busy leaves the shift register unchanged and sets status bit2 (collision).
- R8: If select goes low while the unit is enabled as master, status bit3 (mode fault) sets, the control master bit clears, and the SCLK and MOSI output enables drop.
- R9: As slave, the unit shifts on the external SCLK while select is low. That SCLK must run no faster than fclk/8. The MISO output enable is high only while the unit is enabled, in slave mode and selected.
- R10: irq equals control bit5 AND the OR of status bits 0 to 3. Writing 1 to any of those status bits clears it.
- R11: Status bit0 sets when a character completes. Status bit4 reads 1 while a master transfer runs or while the unit is selected as slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read frees the receive buffer) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 1 | SCLK pin input (slave) |
| sclk_o | output | 1 | SCLK pin output (master) |
| sclk_oe | output | 1 | SCLK output enable |
| mosi_i | input | 1 | MOSI pin input (slave) |
| mosi_o | output | 1 | MOSI pin output (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input (master) |
| miso_o | output | 1 | MISO pin output (slave) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low select pin input |

## Verification
The bench builds the block with its default parameters: 16-bit shift register width, two synchronizer stages and an 8-bit divider field. These defaults make both character lengths and all four clock modes reachable in one build. The divider values used are 0 to 4 and 10, so the fastest fclk/2 rate is measured, and a slow setting holds a transfer open long enough for a second write to collide with it. Slave transfers are run with a bench-generated SCLK at fclk/16, in phase 0 and phase 1.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int DIVW = 8;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic [DIVW-1:0] div;
    logic [1:0]      rsvd;
    logic            ien;
    logic            wide;
    logic            cpha;
    logic            cpol;
    logic            mstr;
    logic            enable;
  } ctl_t;
endpackage

// File: rtl/spi_ctl_clkgen.sv
module spi_ctl_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R4: each half period counts up one step per cycle until the divider value
  p_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (!run || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_raw,
  input  logic ss_n_raw,
  output logic ss_act,
  output logic sedge
);
  logic [STG-1:0] sck_q;
  logic [STG-1:0] ss_q;
  logic           sck_d;

  for (genvar g = 0; g < STG; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q[0] <= 1'b0;
          ss_q[0]  <= 1'b1;
        end else begin
          sck_q[0] <= sclk_raw;
          ss_q[0]  <= ss_n_raw;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q[g] <= 1'b0;
          ss_q[g]  <= 1'b1;
        end else begin
          sck_q[g] <= sck_q[g-1];
          ss_q[g]  <= ss_q[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_q[STG-1];
  end

  assign ss_act = ~ss_q[STG-1];
  assign sedge  = sck_q[STG-1] ^ sck_d;
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  input  logic          edge_i,
  input  logic          din,
  input  logic          cpha,
  input  logic          wide,
  output logic          dout,
  output logic          lvl,
  output logic          fin,
  output logic [DW-1:0] rx
);
  localparam int HALF = DW / 2;
  localparam int CW   = $clog2(2 * DW);

  logic [DW-1:0] sr;
  logic [CW-1:0] ecnt;
  logic          samp;
  logic          lead, last, smp_e, sh_e, step;

  assign lead  = ~ecnt[0];
  assign last  = ecnt == (wide ? CW'(2 * DW - 1) : CW'(DW - 1));
  assign smp_e = cpha ? ~lead : lead;
  assign sh_e  = cpha ? (lead && ecnt != '0) : ~lead;
  assign step  = edge_i && !clr;
  assign fin   = step && last;
  assign dout  = wide ? sr[DW-1] : sr[HALF-1];
  assign rx    = wide ? sr : {{HALF{1'b0}}, sr[HALF-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      lvl  <= 1'b0;
    end else if (clr) begin
      ecnt <= '0;
      lvl  <= 1'b0;
    end else if (edge_i) begin
      lvl  <= ~lvl;
      ecnt <= last ? '0 : ecnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      samp <= 1'b0;
    end else if (load) begin
      sr <= ldata;
    end else if (step) begin
      if (cpha && last)  sr <= {sr[DW-2:0], din};
      else if (sh_e)     sr <= {sr[DW-2:0], samp};
      if (smp_e)         samp <= din;
    end
  end

  // R3: an even number of edges per character brings SCLK back to its idle level
  p_idle_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !lvl);
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DW      = 16,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          sclk_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  localparam int STW = 5;

  ctl_t          ctl;
  logic          f_done, f_ovr, f_col, f_modf;
  logic          rx_full, run, done_q;
  logic [DW-1:0] rbuf;
  logic          ss_act, sedge, tick;
  logic          sel, busy, mfault, dwr, drd, swr, load, start;
  logic          eng_edge, eng_clr, eng_din, dout, lvl, fin;
  logic [DW-1:0] eng_rx;

  assign sel      = ctl.enable && !ctl.mstr && ss_act;
  assign busy     = run || sel;
  assign mfault   = ctl.enable && ctl.mstr && ss_act;
  assign dwr      = reg_wr && reg_addr == A_DATA;
  assign drd      = reg_rd && reg_addr == A_DATA;
  assign swr      = reg_wr && reg_addr == A_STAT;
  assign load     = dwr && !busy;
  assign start    = load && ctl.enable && ctl.mstr && !mfault;
  assign eng_edge = ctl.mstr ? (run && tick) : (sel && sedge);
  assign eng_clr  = !busy;
  assign eng_din  = ctl.mstr ? miso_i : mosi_i;

  spi_ctl_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(ctl.div), .tick(tick)
  );

  spi_ctl_sync #(.STG(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_raw(sclk_i), .ss_n_raw(ss_n_i),
    .ss_act(ss_act), .sedge(sedge)
  );

  spi_ctl_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(eng_clr), .load(load), .ldata(reg_wdata),
    .edge_i(eng_edge), .din(eng_din), .cpha(ctl.cpha), .wide(ctl.wide),
    .dout(dout), .lvl(lvl), .fin(fin), .rx(eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTL) ctl <= reg_wdata;
      if (mfault) ctl.mstr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (!ctl.enable || !ctl.mstr || mfault) run <= 1'b0;
      else if (start)                         run <= 1'b1;
      else if (fin)                           run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_done  <= 1'b0;
      f_ovr   <= 1'b0;
      f_col   <= 1'b0;
      f_modf  <= 1'b0;
      rx_full <= 1'b0;
      rbuf    <= '0;
    end else begin
      if (swr) begin
        f_done <= f_done & ~reg_wdata[0];
        f_ovr  <= f_ovr  & ~reg_wdata[1];
        f_col  <= f_col  & ~reg_wdata[2];
        f_modf <= f_modf & ~reg_wdata[3];
      end
      if (drd) rx_full <= 1'b0;
      if (done_q) begin
        f_done <= 1'b1;
        if (rx_full && !drd) begin
          f_ovr <= 1'b1;
        end else begin
          rbuf    <= eng_rx;
          rx_full <= 1'b1;
        end
      end
      if (dwr && busy) f_col  <= 1'b1;
      if (mfault)      f_modf <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = ctl;
      A_STAT:  reg_rdata = {{(DW-STW){1'b0}}, busy, f_modf, f_col, f_ovr, f_done};
      A_DATA:  reg_rdata = rbuf;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = ctl.ien && (f_done || f_ovr || f_col || f_modf);
  assign sclk_o  = ctl.cpol ^ lvl;
  assign sclk_oe = ctl.enable && ctl.mstr;
  assign mosi_o  = dout;
  assign mosi_oe = ctl.enable && ctl.mstr;
  assign miso_o  = dout;
  assign miso_oe = sel;

  // R9: the unit never drives MISO while it drives SCLK
  p_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> !miso_oe);

  // R6: a completion on top of an unread character keeps the buffer
  p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && rx_full && !drd) |=> ($stable(rbuf) && f_ovr));

  // R7: a data write during a transfer is flagged
  p_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && busy) |=> f_col);

  // R8: select asserted by another device demotes the master
  p_modf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mfault |=> (!ctl.mstr && f_modf && !sclk_oe));

  // R2: the last edge of a character ends the master transfer
  p_run_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && ctl.mstr) |=> !run);
endmodule

// File: tb/sim_spi_ctl.sv
module sim_spi_ctl;
  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic        sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic        sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic        miso_i;
  int          n_chk = 0, n_bad = 0;

  assign miso_i = mosi_o;

  always #4 clk = ~clk;

  spi_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  // {cpol, cpha, wide, pad, div[7:0], tx[15:0]}
  localparam logic [27:0] VT [0:7] = '{
    {4'b0000, 8'd0, 16'hA5C3},
    {4'b0100, 8'd1, 16'h003C},
    {4'b1000, 8'd2, 16'h1281},
    {4'b1100, 8'd3, 16'hFF7E},
    {4'b0010, 8'd1, 16'hBEEF},
    {4'b0110, 8'd0, 16'h8001},
    {4'b1010, 8'd4, 16'h5A3C},
    {4'b1110, 8'd2, 16'h0F0F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk);
    reg_addr = AD; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      peek(AS, s);
      if (!s[4]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha, input int len,
                            input logic [15:0] tx, output logic [15:0] rx,
                            output logic oe_mid);
    rx = 16'h0;
    @(negedge clk);
    sclk_i = cpol;
    @(negedge clk);
    ss_n_i = 1'b0;
    if (!cpha) mosi_i = tx[len-1];
    repeat (H) @(negedge clk);
    oe_mid = miso_oe;
    for (int i = len - 1; i >= 0; i--) begin
      if (!cpha) begin
        sclk_i = ~cpol; rx[i] = miso_o;
        repeat (H) @(negedge clk);
        sclk_i = cpol;
        if (i > 0) mosi_i = tx[i-1];
        repeat (H) @(negedge clk);
      end else begin
        sclk_i = ~cpol; mosi_i = tx[i];
        repeat (H) @(negedge clk);
        sclk_i = cpol; rx[i] = miso_o;
        repeat (H) @(negedge clk);
      end
    end
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d, exp, rxm;
    logic        oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(AC, d); chk("R1 ctl reset", d, 16'h0);
    peek(AS, d); chk("R1 status reset", d, 16'h0);
    chk("R1 oe reset", {sclk_oe, mosi_oe, miso_oe, irq}, 4'b0);

    // vector walk: master loopback over modes, lengths, dividers
    foreach (VT[k]) begin
      logic c_pol, c_pha, c_w;
      logic [7:0] dv;
      logic [15:0] tx;
      int c;
      logic prev;
      {c_pol, c_pha, c_w} = VT[k][27:25];
      dv = VT[k][23:16];
      tx = VT[k][15:0];
      exp = c_w ? tx : {8'h00, tx[7:0]};
      wr(AC, {dv, 2'b00, 1'b0, c_w, c_pha, c_pol, 1'b1, 1'b1});
      @(negedge clk);
      chk("R3 idle sclk", sclk_o, c_pol);
      wr(AD, tx);
      prev = sclk_o; c = 0;
      while (sclk_o == prev && c < 1000) begin @(negedge clk); c++; end
      prev = sclk_o; c = 0;
      while (sclk_o == prev && c < 1000) begin @(negedge clk); c++; end
      chk("R4 half period", c, dv + 1);
      wait_idle();
      chk("R3 sclk back to idle", sclk_o, c_pol);
      peek(AS, d); chk("R11 done flag", d[4:0], 5'b00001);
      pop(d); chk("R2 R5 loopback data", d, exp);
      wr(AS, 16'h001F);
    end

    // R6 overrun keeps first character, R10 irq
    wr(AC, {8'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
    wr(AD, 16'h0011); wait_idle();
    wr(AD, 16'h0022); wait_idle();
    peek(AS, d); chk("R6 overrun flag", d[1], 1'b1);
    chk("R10 irq on flags", irq, 1'b1);
    pop(d); chk("R6 buffer kept", d, 16'h0011);
    wr(AS, 16'h001F);
    @(negedge clk);
    chk("R10 irq cleared by w1c", irq, 1'b0);
    peek(AS, d); chk("R10 status cleared", d, 16'h0);

    // R7 collision during a slow transfer
    wr(AC, {8'd10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
    wr(AD, 16'h005A);
    wr(AD, 16'h00C3);
    peek(AS, d); chk("R7 collision flag", d[2], 1'b1);
    chk("R11 busy during transfer", d[4], 1'b1);
    chk("R10 irq masked", irq, 1'b0);
    wait_idle();
    pop(d); chk("R7 shift reg untouched", d, 16'h005A);
    wr(AS, 16'h001F);

    // R8 mode fault
    wr(AC, {8'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
    @(negedge clk);
    chk("R8 master drives before fault", {sclk_oe, mosi_oe}, 2'b11);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    peek(AS, d); chk("R8 fault flag", d[3], 1'b1);
    peek(AC, d); chk("R8 master bit cleared", d[1], 1'b0);
    chk("R8 drivers released", {sclk_oe, mosi_oe}, 2'b00);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(AS, 16'h001F);

    // R9 slave mode 0, 8-bit
    wr(AC, {8'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
    wr(AD, 16'h0096);
    @(negedge clk);
    chk("R9 miso off when deselected", miso_oe, 1'b0);
    slave_xfer(1'b0, 1'b0, 8, 16'h003C, rxm, oe);
    chk("R9 miso on when selected", oe, 1'b1);
    chk("R9 slave sent preload", rxm, 16'h0096);
    chk("R9 miso off after select", miso_oe, 1'b0);
    pop(d); chk("R9 slave received", d, 16'h003C);
    wr(AS, 16'h001F);

    // R9 slave mode 3, 16-bit
    wr(AC, {8'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
    wr(AD, 16'h4D5E);
    slave_xfer(1'b1, 1'b1, 16, 16'hA1B2, rxm, oe);
    chk("R9 slave16 sent preload", rxm, 16'h4D5E);
    pop(d); chk("R9 slave16 received", d, 16'hA1B2);
    peek(AS, d); chk("R11 slave done", d[4:0], 5'b00001);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule